// File: doc/BRIEF.md
# Cache/Memory Component Register File

This block is a 32-bit memory-mapped register file for the cache/memory register region of a coherent-link component. A host reaches it over a simple byte-addressed bus with separate read and write strobes and a flag that marks an 8-byte access. The block holds a top capability header and an array of capability headers. It also holds an error-reporting group with uncorrectable and correctable status, mask and severity registers. When the component kind provides one, it holds a single host-managed memory decoder group with base, size, control and target-list words.

Each register has a fixed per-bit write mask. Bits outside the mask keep their value on every write. A write to the decoder control register is answered in the same edge: the committed flag follows the commit request and the error flag is cleared. An elaboration-time component-kind parameter sets the advertised capability count, whether the decoder group exists, and the target-list write mask.

Register layout (byte offsets):
- Headers: top header at 0x000, error-group header 0x004, link header 0x008, decoder header 0x00C, security header 0x010, snoop header 0x014.
- Error group at 0x040: uncorrectable status 0x040, uncorrectable mask 0x044, uncorrectable severity 0x048, correctable status 0x04C, correctable mask 0x050, error capability/control 0x054.
- Decoder group at 0x100: capability 0x100, global control 0x104, base low/high 0x108/0x10C, size low/high 0x110/0x114, control 0x118, target list low/high 0x11C/0x120.

Top module: `cm_regfile`

## Requirements
- R1: An access with `dbl_word`=1 is not serviced. A read returns 0x00000000 and a write changes no register.
- R2: A write stores (wdata AND mask) OR (old AND NOT mask). Registers with an all-zero mask (headers, error capability/control 0x054, decoder capability 0x100) never change.
- R3: The decoder control register (0x118, mask 0x13FF) has its commit request in bit 9, its committed flag in bit 10 and its error flag in bit 11. On any write, bit 11 becomes 0 and bit 10 becomes the written bit 9.
- R4: The top header (0x000) reads {count[31:24], 4'h1 at [23:20], 4'h1 at [19:16], 16'h0001}. The count is 2 for downstream ports and plain devices, 3 for upstream ports, type-3 devices and logical devices, and 5 for root ports.
- R5: Each capability header reads {pointer[31:20], version[19:16], id[15:0]}. The values are: error group id 2 version 2 pointer 0x040; link id 4 version 2 pointer 0x080; decoder id 5 version 1 pointer 0x100 (count ≥ 3); security id 6 version 1 pointer 0x180 (count 5); snoop id 8 version 1 pointer 0x1A0 (count 5). A header that is not provided reads 0.
- R6: Error group resets and masks:
  - uncorrectable status: reset 0, mask 0x1CFFF
  - uncorrectable mask and severity: reset 0x1CFFF, mask 0x1CFFF
  - correctable status: reset 0, mask 0x7F
  - correctable mask: reset 0x7F, mask 0x7F
  - error capability/control: reset 0x200, read-only
- R7: Decoder group resets and masks:
  - capability: reset 0x310 (one-decoder code 0, target count 1 at [7:4], 256-byte interleave bit 8, 4 KB interleave bit 9, no poison bit 10)
  - global control: mask 0x3
  - base low and size low: mask 0xF0000000
  - base high and size high: fully writable
  - all other decoder registers reset to 0
- R8: The target list low word has mask 0xF0000000 for device kinds (plain, type-3, logical) and 0xFFFFFFFF for port kinds. The high word is fully writable.
- R9: A misaligned address (addr[1:0]≠0) or an unimplemented address reads 0 and ignores writes. For kinds with count 2 the whole decoder group is unimplemented.
- R10: Read data is registered. It appears one cycle after the read strobe and holds while no read is issued. A read in the same cycle as a write to the same register returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W (12) | Byte address |
| dbl_word | input | 1 | Marks an 8-byte access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |

## Verification
On every cycle the assertions check four things:
- bits outside a register's write mask hold their value;
- the control register's committed and error flags follow a write's commit request;
- a rejected or missed write leaves all register contents untouched;
- 8-byte reads return zero, and read data stays stable while no read is issued.

Only the bench's scenarios can show that the reset values, header encodings and per-kind masks match the numbers required. The same holds for the read-before-write ordering in a shared cycle and for the absence of the decoder group in smaller component kinds.

// File: rtl/cm_regs_pkg.sv
package cm_regs_pkg;

    typedef enum logic [2:0] {
        CT_DOWN_PORT,
        CT_PLAIN_DEV,
        CT_UP_PORT,
        CT_TYPE3_DEV,
        CT_LOGICAL_DEV,
        CT_ROOT_PORT
    } comp_kind_e;

    localparam int HDR_SLOTS = 6;
    localparam int ERR_SLOTS = 6;
    localparam int DEC_SLOTS = 9;
    localparam int NUM_SLOTS = HDR_SLOTS + ERR_SLOTS + DEC_SLOTS;
    localparam int SLOT_W    = $clog2(NUM_SLOTS);
    localparam int ERR_BASE  = HDR_SLOTS;
    localparam int DEC_BASE  = HDR_SLOTS + ERR_SLOTS;

    // word addresses of the groups
    localparam int ERR_WORD = 'h10;
    localparam int DEC_WORD = 'h40;

    // group byte pointers advertised in the headers
    localparam logic [11:0] PTR_ERR  = 12'h040;
    localparam logic [11:0] PTR_LINK = 12'h080;
    localparam logic [11:0] PTR_DEC  = 12'h100;
    localparam logic [11:0] PTR_SEC  = 12'h180;
    localparam logic [11:0] PTR_SNP  = 12'h1A0;

    localparam int SL_TOP      = 0;
    localparam int SL_ERR_HDR  = 1;
    localparam int SL_LINK_HDR = 2;
    localparam int SL_DEC_HDR  = 3;
    localparam int SL_SEC_HDR  = 4;
    localparam int SL_SNP_HDR  = 5;
    localparam int SL_UNC_ST   = ERR_BASE + 0;
    localparam int SL_UNC_MSK  = ERR_BASE + 1;
    localparam int SL_UNC_SEV  = ERR_BASE + 2;
    localparam int SL_COR_ST   = ERR_BASE + 3;
    localparam int SL_COR_MSK  = ERR_BASE + 4;
    localparam int SL_ERR_CAP  = ERR_BASE + 5;
    localparam int SL_DEC_CAP  = DEC_BASE + 0;
    localparam int SL_DEC_GCTL = DEC_BASE + 1;
    localparam int SL_BASE_LO  = DEC_BASE + 2;
    localparam int SL_BASE_HI  = DEC_BASE + 3;
    localparam int SL_SIZE_LO  = DEC_BASE + 4;
    localparam int SL_SIZE_HI  = DEC_BASE + 5;
    localparam int SL_DCTL     = DEC_BASE + 6;
    localparam int SL_TGT_LO   = DEC_BASE + 7;
    localparam int SL_TGT_HI   = DEC_BASE + 8;

    // decoder control bit positions
    localparam int CTL_COMMIT_BIT    = 9;
    localparam int CTL_COMMITTED_BIT = 10;
    localparam int CTL_ERR_BIT       = 11;

    typedef struct packed {
        logic              hit;
        logic [SLOT_W-1:0] idx;
    } slot_sel_t;

    function automatic int cap_count(input comp_kind_e k);
        case (k)
            CT_DOWN_PORT, CT_PLAIN_DEV:               return 2;
            CT_UP_PORT, CT_TYPE3_DEV, CT_LOGICAL_DEV: return 3;
            default:                                  return 5;
        endcase
    endfunction

    function automatic bit is_device(input comp_kind_e k);
        return (k == CT_PLAIN_DEV) || (k == CT_TYPE3_DEV) || (k == CT_LOGICAL_DEV);
    endfunction

    function automatic bit slot_present(input int s, input comp_kind_e k);
        return (s < DEC_BASE) || (cap_count(k) >= 3);
    endfunction

    function automatic logic [31:0] cap_hdr(input logic [15:0] id, input logic [3:0] ver,
                                            input logic [11:0] ptr);
        return {ptr, ver, id};
    endfunction

    function automatic logic [31:0] slot_reset(input int s, input comp_kind_e k);
        int n;
        n = cap_count(k);
        case (s)
            SL_TOP:      return {8'(n), 4'h1, 4'h1, 16'h0001};
            SL_ERR_HDR:  return cap_hdr(16'd2, 4'd2, PTR_ERR);
            SL_LINK_HDR: return cap_hdr(16'd4, 4'd2, PTR_LINK);
            SL_DEC_HDR:  return (n >= 3) ? cap_hdr(16'd5, 4'd1, PTR_DEC) : 32'h0;
            SL_SEC_HDR:  return (n >= 5) ? cap_hdr(16'd6, 4'd1, PTR_SEC) : 32'h0;
            SL_SNP_HDR:  return (n >= 5) ? cap_hdr(16'd8, 4'd1, PTR_SNP) : 32'h0;
            SL_UNC_MSK, SL_UNC_SEV: return 32'h0001_CFFF;
            SL_COR_MSK:  return 32'h0000_007F;
            SL_ERR_CAP:  return 32'h0000_0200;
            SL_DEC_CAP:  return (n >= 3) ? 32'h0000_0310 : 32'h0;
            default:     return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] slot_mask(input int s, input comp_kind_e k);
        case (s)
            SL_UNC_ST, SL_UNC_MSK, SL_UNC_SEV: return 32'h0001_CFFF;
            SL_COR_ST, SL_COR_MSK:             return 32'h0000_007F;
            SL_DEC_GCTL:                       return 32'h0000_0003;
            SL_BASE_LO, SL_SIZE_LO:            return 32'hF000_0000;
            SL_BASE_HI, SL_SIZE_HI, SL_TGT_HI: return 32'hFFFF_FFFF;
            SL_DCTL:                           return 32'h0000_13FF;
            SL_TGT_LO: return is_device(k) ? 32'hF000_0000 : 32'hFFFF_FFFF;
            default:                           return 32'h0;
        endcase
    endfunction

    function automatic slot_sel_t word_to_slot(input logic [29:0] w);
        slot_sel_t r;
        r.hit = 1'b0;
        r.idx = '0;
        if (w < 30'(HDR_SLOTS)) begin
            r.hit = 1'b1;
            r.idx = SLOT_W'(w);
        end else if (w >= 30'(ERR_WORD) && w < 30'(ERR_WORD + ERR_SLOTS)) begin
            r.hit = 1'b1;
            r.idx = SLOT_W'(w - 30'(ERR_WORD) + 30'(ERR_BASE));
        end else if (w >= 30'(DEC_WORD) && w < 30'(DEC_WORD + DEC_SLOTS)) begin
            r.hit = 1'b1;
            r.idx = SLOT_W'(w - 30'(DEC_WORD) + 30'(DEC_BASE));
        end
        return r;
    endfunction

endpackage

// File: rtl/cm_addr_map.sv
module cm_addr_map
    import cm_regs_pkg::*;
#(
    parameter int         ADDR_W = 12,
    parameter comp_kind_e KIND   = CT_TYPE3_DEV
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              dbl_word,
    output slot_sel_t         sel
);
    localparam int WORD_W = ADDR_W - 2;

    slot_sel_t raw;

    always_comb begin
        raw = word_to_slot({{(30 - WORD_W){1'b0}}, addr[ADDR_W-1:2]});
        sel = raw;
        sel.hit = raw.hit && (addr[1:0] == 2'b00) && !dbl_word
                  && slot_present(int'(raw.idx), KIND);
    end
endmodule

// File: rtl/cm_reg_cell.sv
module cm_reg_cell
    import cm_regs_pkg::*;
#(
    parameter logic [31:0] RST     = 32'h0,
    parameter logic [31:0] MSK     = 32'h0,
    parameter bit          IS_CTRL = 1'b0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        we,
    input  logic [31:0] wdata,
    output logic [31:0] q
);
    localparam logic [31:0] FLAG_BITS = (32'h1 << CTL_COMMITTED_BIT) | (32'h1 << CTL_ERR_BIT);
    localparam logic [31:0] FIXED     = IS_CTRL ? ~(MSK | FLAG_BITS) : ~MSK;

    logic [31:0] merged;

    always_comb begin
        merged = (wdata & MSK) | (q & ~MSK);
        if (IS_CTRL) begin
            merged[CTL_ERR_BIT]       = 1'b0;
            merged[CTL_COMMITTED_BIT] = merged[CTL_COMMIT_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)     q <= RST;
        else if (we) q <= merged;
    end

    AST_FIXED_BITS_HOLD: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((q & FIXED) == ($past(q) & FIXED))); // R2

    if (IS_CTRL) begin : g_commit_chk
        AST_COMMIT_FLAGS: assert property (@(posedge clk) disable iff (rst)
            we |=> (q[CTL_COMMITTED_BIT] == $past(wdata[CTL_COMMIT_BIT]))
                   && !q[CTL_ERR_BIT]); // R3
    end
endmodule

// File: rtl/cm_regfile.sv
module cm_regfile
    import cm_regs_pkg::*;
#(
    parameter int         ADDR_W = 12,
    parameter comp_kind_e KIND   = CT_TYPE3_DEV
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              dbl_word,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata
);
    slot_sel_t                     sel;
    logic [NUM_SLOTS-1:0][31:0]    slot_q;

    cm_addr_map #(.ADDR_W(ADDR_W), .KIND(KIND)) u_map (
        .addr     (addr),
        .dbl_word (dbl_word),
        .sel      (sel)
    );

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        localparam logic [31:0] RST_V = slot_present(i, KIND) ? slot_reset(i, KIND) : 32'h0;
        localparam logic [31:0] MSK_V = slot_present(i, KIND) ? slot_mask(i, KIND)  : 32'h0;

        cm_reg_cell #(.RST(RST_V), .MSK(MSK_V), .IS_CTRL(i == SL_DCTL)) u_cell (
            .clk   (clk),
            .rst   (rst),
            .we    (wr_en && sel.hit && (sel.idx == SLOT_W'(i))),
            .wdata (wdata),
            .q     (slot_q[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)         rdata <= 32'h0;
        else if (rd_en)  rdata <= sel.hit ? slot_q[sel.idx] : 32'h0;
    end

    AST_WIDE_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_en && dbl_word) |=> (rdata == 32'h0)); // R1

    AST_MISS_NO_UPDATE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !sel.hit) |=> $stable(slot_q)); // R9

    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata)); // R10
endmodule

// File: tb/test_cm_regfile.sv
`timescale 1ns/1ps
module test_cm_regfile;
    import cm_regs_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, rd_en = 1'b0, dbl_word = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata, rdata_dsp, rdata_rp;
    int          n_chk = 0, n_bad = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    cm_regfile #(.ADDR_W(12), .KIND(CT_TYPE3_DEV)) i_cm_regfile (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .dbl_word(dbl_word), .wdata(wdata), .rdata(rdata));
    cm_regfile #(.ADDR_W(12), .KIND(CT_DOWN_PORT)) i_cm_regfile_dsp (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .dbl_word(dbl_word), .wdata(wdata), .rdata(rdata_dsp));
    cm_regfile #(.ADDR_W(12), .KIND(CT_ROOT_PORT)) i_cm_regfile_rp (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .dbl_word(dbl_word), .wdata(wdata), .rdata(rdata_rp));

    typedef struct packed {
        logic        do_wr;
        logic [11:0] a;
        logic [31:0] wd;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 12'h000, 32'h0,         32'h0311_0001, 8'd4},  // R4 top header
        '{1'b0, 12'h004, 32'h0,         32'h0402_0002, 8'd5},  // R5 error hdr
        '{1'b0, 12'h008, 32'h0,         32'h0802_0004, 8'd5},  // R5 link hdr
        '{1'b0, 12'h00C, 32'h0,         32'h1001_0005, 8'd5},  // R5 decoder hdr
        '{1'b0, 12'h010, 32'h0,         32'h0,         8'd5},  // R5 absent security
        '{1'b0, 12'h044, 32'h0,         32'h0001_CFFF, 8'd6},  // R6
        '{1'b0, 12'h050, 32'h0,         32'h0000_007F, 8'd6},  // R6
        '{1'b0, 12'h054, 32'h0,         32'h0000_0200, 8'd6},  // R6
        '{1'b0, 12'h100, 32'h0,         32'h0000_0310, 8'd7},  // R7
        '{1'b1, 12'h044, 32'hAAAA_AAAA, 32'h0000_8AAA, 8'd2},  // R2
        '{1'b1, 12'h04C, 32'hFFFF_FFFF, 32'h0000_007F, 8'd6},  // R6
        '{1'b1, 12'h054, 32'hFFFF_FFFF, 32'h0000_0200, 8'd2},  // R2
        '{1'b1, 12'h108, 32'h1234_5678, 32'h1000_0000, 8'd7},  // R7
        '{1'b1, 12'h10C, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 8'd7},  // R7
        '{1'b1, 12'h104, 32'h0000_00FF, 32'h0000_0003, 8'd7},  // R7
        '{1'b1, 12'h11C, 32'hFFFF_FFFF, 32'hF000_0000, 8'd8},  // R8 device
        '{1'b1, 12'h118, 32'h0000_0200, 32'h0000_0600, 8'd3},  // R3 commit
        '{1'b1, 12'h118, 32'h0000_0FFF, 32'h0000_07FF, 8'd3},  // R3 err cleared
        '{1'b1, 12'h118, 32'h0000_11FF, 32'h0000_11FF, 8'd3},  // R3 uncommit
        '{1'b1, 12'h100, 32'h0,         32'h0000_0310, 8'd2},  // R2
        '{1'b1, 12'h046, 32'hFFFF_FFFF, 32'h0,         8'd9},  // R9 misaligned
        '{1'b1, 12'h200, 32'hFFFF_FFFF, 32'h0,         8'd9}   // R9 unimplemented
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [11:0] a, input logic [31:0] d, input logic wide);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d; dbl_word = wide;
        @(negedge clk);
        wr_en = 1'b0; dbl_word = 1'b0;
    endtask

    task automatic do_read(input logic [11:0] a, input logic wide);
        @(negedge clk);
        rd_en = 1'b1; addr = a; dbl_word = wide;
        @(negedge clk);
        rd_en = 1'b0; dbl_word = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(4 * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R10 reset rdata", rdata, 32'h0);

        for (int v = 0; v < NV; v++) begin
            if (VECS[v].do_wr) do_write(VECS[v].a, VECS[v].wd, 1'b0);
            do_read(VECS[v].a, 1'b0);
            check($sformatf("R%0d vec%0d", VECS[v].req, v), rdata, VECS[v].exp);
        end

        // R9: misaligned write left the aligned register alone
        do_read(12'h044, 1'b0);
        check("R9 neighbour kept", rdata, 32'h0000_8AAA);
        do_read(12'h058, 1'b0);
        check("R9 gap reads zero", rdata, 32'h0);

        // R1: wide accesses
        do_read(12'h000, 1'b1);
        check("R1 wide read", rdata, 32'h0);
        do_write(12'h10C, 32'h0, 1'b1);
        do_read(12'h10C, 1'b0);
        check("R1 wide write dropped", rdata, 32'hDEAD_BEEF);

        // R10: read and write in one cycle returns the old value
        @(negedge clk);
        rd_en = 1'b1; wr_en = 1'b1; addr = 12'h114; wdata = 32'h55;
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
        check("R10 read before write", rdata, 32'h0);
        do_read(12'h114, 1'b0);
        check("R10 new value", rdata, 32'h55);
        repeat (3) @(negedge clk);
        check("R10 hold", rdata, 32'h55);

        // Component kind without decoder group
        do_read(12'h000, 1'b0);
        check("R4 down port top", rdata_dsp, 32'h0211_0001);
        check("R4 root port top", rdata_rp, 32'h0511_0001);
        do_read(12'h00C, 1'b0);
        check("R5 down port no decoder hdr", rdata_dsp, 32'h0);
        do_read(12'h014, 1'b0);
        check("R5 root snoop hdr", rdata_rp, 32'h1A01_0008);
        do_read(12'h010, 1'b0);
        check("R5 root security hdr", rdata_rp, 32'h1801_0006);
        do_read(12'h100, 1'b0);
        check("R9 down port decoder absent", rdata_dsp, 32'h0);
        do_read(12'h108, 1'b0);
        check("R9 down port write ignored", rdata_dsp, 32'h0);

        // R8: port kind target list fully writable
        do_write(12'h11C, 32'h0000_0A5C, 1'b0);
        do_read(12'h11C, 1'b0);
        check("R8 root port target list", rdata_rp, 32'h0000_0A5C);
        check("R8 device target list", rdata, 32'h0);

        // Reset returns registers to their initial values
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk); rst = 1'b0;
        check("R10 rdata after reset", rdata, 32'h0);
        do_read(12'h118, 1'b0);
        check("R3 control after reset", rdata, 32'h0);
        do_read(12'h108, 1'b0);
        check("R7 base after reset", rdata, 32'h0);
        do_read(12'h044, 1'b0);
        check("R6 unc mask after reset", rdata, 32'h0001_CFFF);

        finish_run();
    end
endmodule